// File: doc/BRIEF.md
# MDIO Management Target

This block is the device side of a two-wire management bus. It follows the MDC clock that an external bus controller drives and shifts bits in on MDC rising edges. It recognises frames in both the short format and the extended format, and it serves a small internal bank of 16-bit registers. Both MDC and MDIO are sampled with the system clock through a two-flop synchroniser. The system clock must run at least about ten times faster than MDC, so that each MDC half period lasts more than four system clocks.

A frame is only accepted after a run of at least 32 consecutive ones. The second start bit picks the format.

- **Short frames** address a register in bank 0 directly.
- **Extended frames** select a bank through the low bits of the device field. They work through a 16-bit pointer held per bank. An address frame loads that pointer. Extended writes and reads use the pointer, and one read variant increments it after fetching.

The block drives MDIO only during the second turnaround bit and the 16 data bits of a read. It does so only when the frame's port field equals its strap input. Output changes happen only in response to MDC rising edges.

Top module: `mdio_target`

## Requirements
- R1: After reset the output enable and the data output are low, every register reads 0x0000 and every bank pointer is 0x0000.
- R2: A frame is recognised only when at least 32 consecutive ones are followed by a 0. A run of fewer ones followed by a frame body has no effect. After any frame ends or is dropped, a new run of 32 ones is needed.
- R3: The bit after the first start bit selects the format: 1 selects a short frame and 0 selects an extended frame. A short frame uses the low 3 bits of the 5-bit register field as the index into bank 0. An extended frame uses the low bit of the 5-bit device field as the bank and the low 3 bits of that bank's pointer as the index.
- R4: In a short frame, an opcode whose first bit is 0 writes the 16 data bits (MSB first) into the register. An opcode whose first bit is 1 reads that register.
- R5: On a read, the output enable stays low for the first turnaround bit. The block then drives 0 for the second turnaround bit and the 16 data bits MSB first, and releases the line at the next MDC rising edge. The output enable and the data output change only after an MDC rising edge.
- R6: An extended frame with opcode 0,0 loads its 16 data bits into the selected bank's pointer and leaves all other pointers and registers unchanged.
- R7: An extended frame with opcode 0,1 writes its data into the register at the selected bank's pointer.
- R8: An extended frame with opcode 1,1 returns the register at the pointer and leaves the pointer unchanged.
- R9: An extended frame with opcode 1,0 returns the register at the pointer and then adds one to the pointer, wrapping from 0xFFFF to 0x0000.
- R10: When the 5-bit port field differs from the strap input, the output enable stays low for the whole frame, and writes and address loads have no effect.
- R11: A write or address frame whose turnaround bits are not 1 then 0 is dropped with no effect on registers or pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mdc_i | input | 1 | Management clock from the bus controller (asynchronous) |
| mdio_i | input | 1 | Management data line as seen at the pad |
| mdio_o | output | 1 | Data value driven when the enable is high |
| mdio_oe_o | output | 1 | Output enable for the data pad |
| port_addr_i | input | 5 | Strapped port address that this target answers |

## Verification
A wrong bit counter or field shift shows up within the same frame. The read word comes back shifted, or the turnaround zero is missing, in the slots right after the register field. A pointer that fails to increment or load is invisible until the next extended read of that bank, so the sweeps always follow pointer changes with reads. A preamble counter that accepts short runs, or a dropped frame that is committed anyway, only shows on a later read-back. For that reason every rejected frame is followed by a read of the register or pointer it could have changed.

// File: rtl/mdio_target_pkg.sv
package mdio_target_pkg;
    // Protocol constants fixed by the bus frame format
    localparam int PRE_BITS = 32;
    localparam int FIELD_W  = 5;
    localparam int WORD_W   = 16;
    localparam int CNT_W    = 6;

    typedef enum logic [2:0] {
        S_HUNT,
        S_START2,
        S_OPCODE,
        S_PORT,
        S_REG,
        S_TURN,
        S_DATA
    } frame_st_e;
endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc_i,
    input  logic mdio_i,
    output logic rise_o,
    output logic bit_o
);
    typedef struct packed {
        logic [STAGES-1:0] clk_sh;
        logic [STAGES-1:0] dat_sh;
        logic              last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.clk_sh = {s_q.clk_sh[STAGES-2:0], mdc_i};
        s_d.dat_sh = {s_q.dat_sh[STAGES-2:0], mdio_i};
        s_d.last   = s_q.clk_sh[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise_o = s_q.clk_sh[STAGES-1] & ~s_q.last;
    assign bit_o  = s_q.dat_sh[STAGES-1];

    // R5
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/mdio_regbank.sv
module mdio_regbank #(
    parameter int NUM_DEV      = 2,
    parameter int REGS_PER_DEV = 8,
    localparam int DEV_W  = $clog2(NUM_DEV),
    localparam int IDX_W  = $clog2(REGS_PER_DEV),
    localparam int ADDR_W = DEV_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [15:0]       rd_data_o,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [15:0]       wr_data_i,
    input  logic [DEV_W-1:0]  ptr_dev_i,
    input  logic              ptr_load_i,
    input  logic [15:0]       ptr_val_i,
    input  logic              ptr_inc_i,
    output logic [IDX_W-1:0]  ptr_o
);
    // NUM_DEV and REGS_PER_DEV are powers of two, so every address is in range
    localparam int DEPTH = NUM_DEV * REGS_PER_DEV;

    typedef struct packed {
        logic [DEPTH-1:0][15:0]   mem;
        logic [NUM_DEV-1:0][15:0] ptr;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (wr_en_i) b_d.mem[wr_addr_i] = wr_data_i;
        if (ptr_load_i)     b_d.ptr[ptr_dev_i] = ptr_val_i;
        else if (ptr_inc_i) b_d.ptr[ptr_dev_i] = b_q.ptr[ptr_dev_i] + 16'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign rd_data_o = b_q.mem[rd_addr_i];
    assign ptr_o     = b_q.ptr[ptr_dev_i][IDX_W-1:0];

    // R9
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_inc_i && !ptr_load_i) |=> b_q.ptr[ptr_dev_i] == $past(b_q.ptr[ptr_dev_i]) + 16'd1);
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_target_pkg::*;
#(
    parameter int NUM_DEV      = 2,
    parameter int REGS_PER_DEV = 8,
    localparam int DEV_W  = $clog2(NUM_DEV),
    localparam int IDX_W  = $clog2(REGS_PER_DEV),
    localparam int ADDR_W = DEV_W + IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rise_i,
    input  logic               bit_i,
    input  logic [FIELD_W-1:0] port_addr_i,
    output logic [ADDR_W-1:0]  rd_addr_o,
    input  logic [WORD_W-1:0]  rd_data_i,
    output logic               wr_en_o,
    output logic [ADDR_W-1:0]  wr_addr_o,
    output logic [WORD_W-1:0]  wr_data_o,
    output logic [DEV_W-1:0]   ptr_dev_o,
    output logic               ptr_load_o,
    output logic [WORD_W-1:0]  ptr_val_o,
    output logic               ptr_inc_o,
    input  logic [IDX_W-1:0]   ptr_i,
    output logic               mdio_o,
    output logic               mdio_oe_o
);
    localparam logic [CNT_W-1:0] PRE_FULL   = CNT_W'(PRE_BITS);
    localparam logic [CNT_W-1:0] LAST_FIELD = CNT_W'(FIELD_W - 1);
    localparam logic [CNT_W-1:0] LAST_DATA  = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

    typedef struct packed {
        frame_st_e          st;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   pre;
        logic               ext;
        logic [1:0]         op;
        logic [FIELD_W-1:0] port;
        logic [FIELD_W-1:0] regad;
        logic [WORD_W-1:0]  sh;
        logic               oe;
        logic               out;
    } fsm_t;

    fsm_t f_d, f_q;
    logic hit, is_read, commit;

    always_comb begin
        hit        = (f_q.port == port_addr_i);
        is_read    = f_q.op[1];
        ptr_dev_o  = f_q.regad[DEV_W-1:0];
        rd_addr_o  = f_q.ext ? {f_q.regad[DEV_W-1:0], ptr_i}
                             : {{DEV_W{1'b0}}, f_q.regad[IDX_W-1:0]};
        wr_addr_o  = rd_addr_o;
        wr_data_o  = WORD_W'({f_q.sh, bit_i});
        ptr_val_o  = wr_data_o;
        commit     = rise_i && (f_q.st == S_DATA) && (f_q.cnt == LAST_DATA) && !is_read && hit;
        wr_en_o    = commit && (!f_q.ext || f_q.op[0]);
        ptr_load_o = commit && f_q.ext && !f_q.op[0];
        ptr_inc_o  = rise_i && (f_q.st == S_TURN) && (f_q.cnt == '0) && is_read
                     && f_q.ext && !f_q.op[0] && hit;
    end

    always_comb begin
        f_d = f_q;
        if (rise_i) begin
            f_d.oe  = 1'b0;
            f_d.out = 1'b0;
            unique case (f_q.st)
                S_HUNT: begin
                    if (bit_i) begin
                        if (f_q.pre != PRE_FULL) f_d.pre = f_q.pre + 1'b1;
                    end else if (f_q.pre == PRE_FULL) begin
                        f_d.st = S_START2;
                    end else begin
                        f_d.pre = '0;
                    end
                end
                S_START2: begin
                    f_d.ext = !bit_i;
                    f_d.pre = '0;
                    f_d.cnt = '0;
                    f_d.st  = S_OPCODE;
                end
                S_OPCODE: begin
                    f_d.op  = 2'({f_q.op, bit_i});
                    f_d.cnt = f_q.cnt + 1'b1;
                    if (f_q.cnt == ONE) begin
                        f_d.cnt = '0;
                        f_d.st  = S_PORT;
                    end
                end
                S_PORT: begin
                    f_d.port = FIELD_W'({f_q.port, bit_i});
                    f_d.cnt  = f_q.cnt + 1'b1;
                    if (f_q.cnt == LAST_FIELD) begin
                        f_d.cnt = '0;
                        f_d.st  = S_REG;
                    end
                end
                S_REG: begin
                    f_d.regad = FIELD_W'({f_q.regad, bit_i});
                    f_d.cnt   = f_q.cnt + 1'b1;
                    if (f_q.cnt == LAST_FIELD) begin
                        f_d.cnt = '0;
                        f_d.st  = S_TURN;
                    end
                end
                S_TURN: begin
                    if (is_read) begin
                        if (f_q.cnt == '0) begin
                            f_d.sh  = rd_data_i;
                            f_d.cnt = ONE;
                        end else begin
                            f_d.oe  = hit;
                            f_d.cnt = '0;
                            f_d.st  = S_DATA;
                        end
                    end else if (bit_i != (f_q.cnt == '0)) begin
                        f_d.cnt = '0;
                        f_d.st  = S_HUNT;
                    end else if (f_q.cnt == '0) begin
                        f_d.cnt = ONE;
                    end else begin
                        f_d.cnt = '0;
                        f_d.st  = S_DATA;
                    end
                end
                S_DATA: begin
                    f_d.cnt = f_q.cnt + 1'b1;
                    if (is_read) begin
                        f_d.oe  = hit;
                        f_d.out = f_q.sh[WORD_W-1];
                        f_d.sh  = WORD_W'({f_q.sh, 1'b0});
                    end else begin
                        f_d.sh  = wr_data_o;
                    end
                    if (f_q.cnt == LAST_DATA) begin
                        f_d.cnt = '0;
                        f_d.st  = S_HUNT;
                    end
                end
                default: f_d.st = S_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign mdio_o    = f_q.out;
    assign mdio_oe_o = f_q.oe;

    // R5
    oe_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe_o != $past(mdio_oe_o)) |-> $past(rise_i));
    // R5
    out_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_o != $past(mdio_o)) |-> $past(rise_i));
    // R5
    turn_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe_o) |-> !mdio_o);
    // R10
    drive_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe_o |-> (f_q.port == port_addr_i) && f_q.op[1]);
    // R2
    preamble_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == S_START2) |-> (f_q.pre == PRE_FULL));
endmodule

// File: rtl/mdio_target.sv
module mdio_target #(
    parameter int NUM_DEV      = 2,
    parameter int REGS_PER_DEV = 8,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mdc_i,
    input  logic       mdio_i,
    output logic       mdio_o,
    output logic       mdio_oe_o,
    input  logic [4:0] port_addr_i
);
    localparam int DEV_W  = $clog2(NUM_DEV);
    localparam int IDX_W  = $clog2(REGS_PER_DEV);
    localparam int ADDR_W = DEV_W + IDX_W;

    logic              rise_w, bit_w;
    logic [ADDR_W-1:0] rd_addr_w, wr_addr_w;
    logic [15:0]       rd_data_w, wr_data_w, ptr_val_w;
    logic              wr_en_w, ptr_load_w, ptr_inc_w;
    logic [DEV_W-1:0]  ptr_dev_w;
    logic [IDX_W-1:0]  ptr_w;

    mdio_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .mdc_i  (mdc_i),
        .mdio_i (mdio_i),
        .rise_o (rise_w),
        .bit_o  (bit_w)
    );

    mdio_frame_fsm #(.NUM_DEV(NUM_DEV), .REGS_PER_DEV(REGS_PER_DEV)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_i      (rise_w),
        .bit_i       (bit_w),
        .port_addr_i (port_addr_i),
        .rd_addr_o   (rd_addr_w),
        .rd_data_i   (rd_data_w),
        .wr_en_o     (wr_en_w),
        .wr_addr_o   (wr_addr_w),
        .wr_data_o   (wr_data_w),
        .ptr_dev_o   (ptr_dev_w),
        .ptr_load_o  (ptr_load_w),
        .ptr_val_o   (ptr_val_w),
        .ptr_inc_o   (ptr_inc_w),
        .ptr_i       (ptr_w),
        .mdio_o      (mdio_o),
        .mdio_oe_o   (mdio_oe_o)
    );

    mdio_regbank #(.NUM_DEV(NUM_DEV), .REGS_PER_DEV(REGS_PER_DEV)) bank_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_addr_i  (rd_addr_w),
        .rd_data_o  (rd_data_w),
        .wr_en_i    (wr_en_w),
        .wr_addr_i  (wr_addr_w),
        .wr_data_i  (wr_data_w),
        .ptr_dev_i  (ptr_dev_w),
        .ptr_load_i (ptr_load_w),
        .ptr_val_i  (ptr_val_w),
        .ptr_inc_i  (ptr_inc_w),
        .ptr_o      (ptr_w)
    );
endmodule

// File: tb/mdio_target_tb_top.sv
module mdio_target_tb_top;
    localparam int         HALF    = 6;
    localparam logic [4:0] MY_PORT = 5'h0B;

    logic clk = 1'b0, rst_n = 1'b0, mdc = 1'b0, ctl_en = 1'b0, ctl_bit = 1'b0;
    logic mdio_o, mdio_oe, bus;
    logic [4:0] strap = MY_PORT;

    // pulled-up shared line
    assign bus = ctl_en ? ctl_bit : (mdio_oe ? mdio_o : 1'b1);
    always #4 clk = ~clk;

    mdio_target dut_i (
        .clk(clk), .rst_n(rst_n), .mdc_i(mdc), .mdio_i(bus),
        .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .port_addr_i(strap)
    );

    int checks = 0, fails = 0, clash = 0, oe_cyc = 0;
    bit done = 1'b0;
    logic [15:0] exp_mem [16];
    logic [15:0] rd_q;
    logic        shape_q, rel_q;

    always @(posedge clk) begin
        if (ctl_en && mdio_oe) clash++;
        if (mdio_oe) oe_cyc++;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic slot(input logic drive, input logic val, output logic s_oe, output logic s_val);
        @(negedge clk);
        ctl_en = drive; ctl_bit = val;
        repeat (HALF) @(negedge clk);
        mdc = 1'b1;
        repeat (HALF) @(negedge clk);
        s_oe = mdio_oe; s_val = mdio_o;
        mdc = 1'b0;
    endtask

    task automatic frame(input int pre_n, input logic ext, input logic [1:0] op, input logic [4:0] pa,
                         input logic [4:0] ra, input logic [15:0] wd, input logic [1:0] ta);
        logic o, v;
        slot(1'b1, 1'b0, o, v);
        for (int i = 0; i < pre_n; i++) slot(1'b1, 1'b1, o, v);
        slot(1'b1, 1'b0, o, v);
        slot(1'b1, !ext, o, v);
        for (int i = 1; i >= 0; i--) slot(1'b1, op[i], o, v);
        for (int i = 4; i >= 0; i--) slot(1'b1, pa[i], o, v);
        for (int i = 4; i >= 0; i--) slot(1'b1, ra[i], o, v);
        shape_q = 1'b1;
        if (op[1]) begin
            slot(1'b0, 1'b0, o, v); shape_q &= !o;
            slot(1'b0, 1'b0, o, v); shape_q &= o & !v;
            for (int i = 0; i < 16; i++) begin
                slot(1'b0, 1'b0, o, v);
                shape_q &= o;
                rd_q = {rd_q[14:0], v};
            end
        end else begin
            slot(1'b1, ta[1], o, v);
            slot(1'b1, ta[0], o, v);
            for (int i = 15; i >= 0; i--) slot(1'b1, wd[i], o, v);
        end
        slot(1'b0, 1'b0, o, v);
        rel_q = !o;
    endtask

    task automatic wr_s(input logic [4:0] ra, input logic [15:0] d);
        frame(32, 1'b0, 2'b01, MY_PORT, ra, d, 2'b10);
    endtask
    task automatic rd_s(input logic [4:0] ra);
        frame(32, 1'b0, 2'b10, MY_PORT, ra, 16'h0, 2'b10);
    endtask
    task automatic x_addr(input logic [4:0] dv, input logic [15:0] a);
        frame(32, 1'b1, 2'b00, MY_PORT, dv, a, 2'b10);
    endtask
    task automatic x_wr(input logic [4:0] dv, input logic [15:0] d);
        frame(32, 1'b1, 2'b01, MY_PORT, dv, d, 2'b10);
    endtask
    task automatic x_rd(input logic [4:0] dv, input logic inc);
        frame(32, 1'b1, inc ? 2'b10 : 2'b11, MY_PORT, dv, 16'h0, 2'b10);
    endtask

    initial begin
        logic [15:0] d;
        int base;
        for (int i = 0; i < 16; i++) exp_mem[i] = 16'h0;
        repeat (5) @(negedge clk);
        // R1 reset outputs
        chk(!mdio_oe && !mdio_o, "R1 reset outputs", {30'h0, mdio_oe, mdio_o}, 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 bank 0 zero after reset, R5 read waveform
        for (int r = 0; r < 8; r++) begin
            rd_s(5'(r));
            chk(rd_q == 16'h0, "R1 bank0 reset value", 32'(rd_q), 32'h0);
            chk(shape_q && rel_q, "R5 read turnaround/data/release", {30'h0, shape_q, rel_q}, 32'h3);
        end
        // R1 bank 1 zero, walked by post-increment reads (R9)
        x_addr(5'd1, 16'h0000);
        for (int r = 0; r < 8; r++) begin
            x_rd(5'd1, 1'b1);
            chk(rd_q == 16'h0, "R1 bank1 reset value via R9 walk", 32'(rd_q), 32'h0);
        end

        // R4 short writes, read back through aliased register field (R3)
        for (int r = 0; r < 8; r++) begin
            d = 16'((r + 1) * 16'h2B3D);
            exp_mem[r] = d;
            wr_s(5'(r), d);
        end
        for (int r = 0; r < 8; r++) begin
            rd_s(5'(r + 8 * (r % 4)));
            chk(rd_q == exp_mem[r], "R4 short write/read R3 alias", 32'(rd_q), 32'(exp_mem[r]));
            chk(shape_q && rel_q, "R5 read waveform", {30'h0, shape_q, rel_q}, 32'h3);
        end

        // R6/R7 extended address then write into bank 1
        for (int r = 0; r < 8; r++) begin
            d = 16'((r + 3) * 16'h1F71);
            exp_mem[8 + r] = d;
            x_addr(5'd1, 16'(16'h0040 + r));
            x_wr(5'd1, d);
        end
        // R8 plain extended read keeps pointer
        x_addr(5'd1, 16'h0005);
        x_rd(5'd1, 1'b0);
        chk(rd_q == exp_mem[13], "R8 extended read", 32'(rd_q), 32'(exp_mem[13]));
        x_rd(5'd1, 1'b0);
        chk(rd_q == exp_mem[13], "R8 pointer unchanged", 32'(rd_q), 32'(exp_mem[13]));
        // R9 post-increment walk
        x_addr(5'd1, 16'h0000);
        for (int r = 0; r < 8; r++) begin
            x_rd(5'd1, 1'b1);
            chk(rd_q == exp_mem[8 + r], "R9 post-increment read R7 data", 32'(rd_q), 32'(exp_mem[8 + r]));
        end
        x_rd(5'd1, 1'b0);
        chk(rd_q == exp_mem[8], "R9 pointer advanced to 8", 32'(rd_q), 32'(exp_mem[8]));
        // R9 wrap
        x_addr(5'd1, 16'hFFFF);
        x_rd(5'd1, 1'b1);
        chk(rd_q == exp_mem[15], "R9 read at 0xFFFF", 32'(rd_q), 32'(exp_mem[15]));
        x_rd(5'd1, 1'b0);
        chk(rd_q == exp_mem[8], "R9 wrap to 0x0000", 32'(rd_q), 32'(exp_mem[8]));

        // R3 extended frame to bank 0, R6 other bank pointer untouched
        x_addr(5'd0, 16'h0006);
        x_wr(5'd0, 16'hC0DE);
        exp_mem[6] = 16'hC0DE;
        rd_s(5'd6);
        chk(rd_q == 16'hC0DE, "R3 extended bank0 seen by short read", 32'(rd_q), 32'hC0DE);
        x_rd(5'd1, 1'b0);
        chk(rd_q == exp_mem[8], "R6 bank1 pointer unaffected", 32'(rd_q), 32'(exp_mem[8]));

        // R10 sweep over every foreign port address
        for (int p = 0; p < 32; p++) begin
            if (5'(p) != MY_PORT) begin
                frame(32, 1'b0, 2'b01, 5'(p), 5'd2, 16'(p * 257) ^ 16'h5A5A, 2'b10);
                base = oe_cyc;
                frame(32, 1'b0, 2'b10, 5'(p), 5'd2, 16'h0, 2'b10);
                chk(oe_cyc == base, "R10 no drive on foreign read", 32'(oe_cyc - base), 32'h0);
                if (p < 4) frame(32, 1'b1, 2'b00, 5'(p), 5'd1, 16'h0003, 2'b10);
            end
        end
        rd_s(5'd2);
        chk(rd_q == exp_mem[2], "R10 foreign writes ignored", 32'(rd_q), 32'(exp_mem[2]));
        x_rd(5'd1, 1'b0);
        chk(rd_q == exp_mem[8], "R10 foreign address load ignored", 32'(rd_q), 32'(exp_mem[8]));

        // R11 bad turnaround, then frame without preamble (R2)
        for (int t = 0; t < 3; t++) begin
            frame(32, 1'b0, 2'b01, MY_PORT, 5'd3, 16'hFFFF, (t == 0) ? 2'b00 : (t == 1) ? 2'b01 : 2'b11);
            frame(0, 1'b0, 2'b01, MY_PORT, 5'd3, 16'h7777, 2'b10);
            rd_s(5'd3);
            chk(rd_q == exp_mem[3], "R11 bad turnaround dropped, R2 no preamble", 32'(rd_q), 32'(exp_mem[3]));
        end
        frame(32, 1'b1, 2'b00, MY_PORT, 5'd1, 16'h0004, 2'b00);
        x_rd(5'd1, 1'b0);
        chk(rd_q == exp_mem[8], "R11 bad turnaround address dropped", 32'(rd_q), 32'(exp_mem[8]));

        // R2 preamble length
        frame(31, 1'b0, 2'b01, MY_PORT, 5'd4, 16'hBEEF, 2'b10);
        rd_s(5'd4);
        chk(rd_q == exp_mem[4], "R2 31-bit preamble ignored", 32'(rd_q), 32'(exp_mem[4]));
        frame(40, 1'b0, 2'b01, MY_PORT, 5'd4, 16'hBEEF, 2'b10);
        exp_mem[4] = 16'hBEEF;
        rd_s(5'd4);
        chk(rd_q == 16'hBEEF, "R2 long preamble accepted", 32'(rd_q), 32'hBEEF);

        chk(clash == 0, "R5 no drive while controller drives", 32'(clash), 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule